// File: doc/BRIEF.md
# Programmable Smart Card Clock Generator

This block derives the clock for a smart card from the master clock. It has two independent channels. One makes the clock for a card on the internal interface, and the other makes the clock for a card on the external interface. Software sets each channel with a 6-bit divisor code, held in its own 8-bit register on a simple write/read bus. Address 0 selects the internal channel and address 1 selects the external channel.

Each channel divides in two stages. A prescaler divides the master clock by (N+1), where N is the channel's code. Each time the prescaler wraps, it issues a one-cycle tick. That tick is meant to step a downstream elementary-time-unit divider. A toggle stage then halves the tick rate, which gives a card clock with a 50% duty cycle and a period of 2*(N+1) master clocks.

A code of 0 is treated as 1. A new code waits in its register and reaches the dividers only when the card clock falls at the end of a full period. As a result, no phase is ever cut short or stretched to an odd length.

Top module: `sc_clkgen_top`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0x0C, both card clocks are low and both ticks are low. The first card clock period then has a high phase of 13 master clocks.
- R2: A read returns the most recently written 6-bit code in bits 5..0, with bits 7..6 reading as zero. The read reflects the write in the cycle after it, even before the code has been applied to the divider.
- R3: With an effective divisor E, the tick asserts for exactly one master clock cycle, once every E+1 master clock cycles.
- R4: With an effective divisor E, the card clock high phase and low phase each last E+1 master clock cycles, giving a period of 2*(E+1).
- R5: A code of 0 produces the same tick spacing and card clock phases as a code of 1 (E = 1).
- R6: A newly written code takes effect only at a falling edge of the card clock. The phase in progress, and the rest of the current period, keep the old length.
- R7: Address 0 writes only the internal channel and address 1 writes only the external channel. Writing one channel changes neither the other channel's register nor its clock.
- R8: The card clock changes state only on the edge that also raises the tick, and every phase lasts at least two master clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 internal, 1 external |
| bus_wdata | input | 8 | Write data; bits 5..0 form the code |
| bus_rdata | output | 8 | Read data for the selected register |
| int_tick | output | 1 | Internal channel prescaler tick |
| int_cclk | output | 1 | Internal card clock |
| ext_tick | output | 1 | External channel prescaler tick |
| ext_cclk | output | 1 | External card clock |

## Verification
The bench uses the default build: two channels with a 6-bit code. At that size, all 64 codes can be swept on both channels in one run. During the sweep the two channels carry different codes, so the zero-as-one case and the longest divisor are both measured directly. Targeted writes land in the middle of a high phase and in the middle of a low phase, to show that the phase boundaries stay intact.

// File: rtl/sc_clk_pkg.sv
// Shared constants for the smart card clock generator.
// Assumes exactly two channels: index 0 is internal, index 1 is external.
package sc_clk_pkg;
    localparam int DEF_FSEL_W     = 6;
    localparam int DEF_REG_W      = 8;
    localparam int DEF_RESET_CODE = 12;
    localparam int NUM_CH         = 2;
    localparam int ADDR_W         = 1;
    localparam int CH_INT         = 0;
    localparam int CH_EXT         = 1;
endpackage

// File: rtl/sc_fsel_reg.sv
// Frequency-select register for one channel.
// It captures the low FSEL_W bits of a write to its own address.
// It assumes REG_W >= FSEL_W; the upper bits are not stored.
module sc_fsel_reg #(
    parameter int FSEL_W     = 6,
    parameter int ADDR_W     = 1,
    parameter int MY_ADDR    = 0,
    parameter int RESET_CODE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [FSEL_W-1:0] wdata,
    output logic [FSEL_W-1:0] code
);
    // Hold the pending code; reset loads the default.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code <= RESET_CODE[FSEL_W-1:0];
        else if (wr && (addr == ADDR_W'(MY_ADDR)))
            code <= wdata;
    end
endmodule

// File: rtl/sc_clk_chan.sv
// One clock channel: a prescaler by (E+1) followed by a toggle stage.
// E is the active code, with 0 treated as 1.
// The pending code moves into the active code only when the card clock
// falls (terminal count while the clock is high), so every period is
// built from a single divisor. Tick and card clock are both flip-flop outputs.
module sc_clk_chan #(
    parameter int FSEL_W     = 6,
    parameter int RESET_CODE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FSEL_W-1:0] pend_code,
    output logic              tick,
    output logic              cclk
);
    logic [FSEL_W-1:0] act_code;
    logic [FSEL_W-1:0] eff_code;
    logic [FSEL_W-1:0] cnt;
    logic              term;

    // Map a code of zero onto a code of one.
    always_comb eff_code = (act_code == '0) ? FSEL_W'(1) : act_code;

    // Terminal count of the prescaler.
    always_comb term = (cnt == eff_code);

    // Prescaler, tick, toggle stage and divisor hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            tick     <= 1'b0;
            cclk     <= 1'b0;
            act_code <= RESET_CODE[FSEL_W-1:0];
        end else begin
            cnt  <= term ? '0 : cnt + 1'b1;
            tick <= term;
            if (term)
                cclk <= ~cclk;
            if (term && cclk)
                act_code <= pend_code;
        end
    end
endmodule

// File: rtl/sc_clkgen_top.sv
// Two-channel smart card clock generator with a small register bus.
// Address 0 is the internal channel and address 1 is the external channel.
// Reads are combinational from the pending registers.
module sc_clkgen_top
    import sc_clk_pkg::*;
#(
    parameter int FSEL_W     = DEF_FSEL_W,
    parameter int REG_W      = DEF_REG_W,
    parameter int RESET_CODE = DEF_RESET_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              int_tick,
    output logic              int_cclk,
    output logic              ext_tick,
    output logic              ext_cclk
);
    logic [NUM_CH-1:0][FSEL_W-1:0] pend;
    logic [NUM_CH-1:0]             tick_v;
    logic [NUM_CH-1:0]             cclk_v;
    logic                          unused_hi_bits;

    assign unused_hi_bits = ^bus_wdata[REG_W-1:FSEL_W];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        sc_fsel_reg #(
            .FSEL_W    (FSEL_W),
            .ADDR_W    (ADDR_W),
            .MY_ADDR   (ch),
            .RESET_CODE(RESET_CODE)
        ) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .wr   (bus_wr),
            .addr (bus_addr),
            .wdata(bus_wdata[FSEL_W-1:0]),
            .code (pend[ch])
        );

        sc_clk_chan #(
            .FSEL_W    (FSEL_W),
            .RESET_CODE(RESET_CODE)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .pend_code(pend[ch]),
            .tick     (tick_v[ch]),
            .cclk     (cclk_v[ch])
        );
    end

    // Read mux: the selected code, zero-extended to the register width.
    always_comb begin
        bus_rdata = '0;
        for (int ch = 0; ch < NUM_CH; ch++)
            if (bus_addr == ADDR_W'(ch))
                bus_rdata[FSEL_W-1:0] = pend[ch];
    end

    assign int_tick = tick_v[CH_INT];
    assign int_cclk = cclk_v[CH_INT];
    assign ext_tick = tick_v[CH_EXT];
    assign ext_cclk = cclk_v[CH_EXT];
endmodule

// File: rtl/sc_clkgen_chk.sv
// Property checker for sc_clkgen_top, attached with bind below.
// It watches only the top-level ports.
module sc_clkgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       int_tick,
    input logic       int_cclk,
    input logic       ext_tick,
    input logic       ext_cclk
);
    // R1
    reset_out_chk: assert property (@(posedge clk)
        !rst_n |=> (!int_cclk && !ext_cclk && !int_tick && !ext_tick));

    // R2
    rdata_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:6] == 2'b00);

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> ((bus_addr != $past(bus_addr)) ||
                    (bus_rdata[5:0] == $past(bus_wdata[5:0]))));

    // R3
    int_tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_tick |=> !int_tick);

    // R3
    ext_tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_tick |=> !ext_tick);

    // R8
    int_edge_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_cclk != $past(int_cclk)) |-> int_tick);

    // R8
    ext_edge_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cclk != $past(ext_cclk)) |-> ext_tick);

    // R8
    int_min_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_cclk != $past(int_cclk)) |=> $stable(int_cclk));

    // R8
    ext_min_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cclk != $past(ext_cclk)) |=> $stable(ext_cclk));
endmodule

bind sc_clkgen_top sc_clkgen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .int_tick (int_tick),
    .int_cclk (int_cclk),
    .ext_tick (ext_tick),
    .ext_cclk (ext_cclk)
);

// File: tb/tb_sc_clkgen_top.sv
// Self-checking bench: sweeps every code on both channels and measures
// phases and tick spacing at the ports.
module tb_sc_clkgen_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       int_tick, int_cclk, ext_tick, ext_cclk;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    logic [1:0] cclk_v, tick_v;
    assign cclk_v = {ext_cclk, int_cclk};
    assign tick_v = {ext_tick, int_tick};

    int   run     [2];
    int   last_hi [2];
    int   last_lo [2];
    int   gap     [2];
    int   since   [2];
    logic prev    [2];

    sc_clkgen_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .int_tick(int_tick), .int_cclk(int_cclk),
        .ext_tick(ext_tick), .ext_cclk(ext_cclk)
    );

    always #10 clk = ~clk;

    // Phase-length and tick-gap monitor, sampled at the falling edge.
    always @(negedge clk) begin
        for (int ch = 0; ch < 2; ch++) begin
            if (!rst_n) begin
                run[ch] = 0; prev[ch] = 1'b0; since[ch] = 0;
                last_hi[ch] = 0; last_lo[ch] = 0; gap[ch] = 0;
            end else begin
                if (cclk_v[ch] == prev[ch]) run[ch]++;
                else begin
                    if (prev[ch]) last_hi[ch] = run[ch];
                    else          last_lo[ch] = run[ch];
                    run[ch] = 1;
                end
                prev[ch] = cclk_v[ch];
                since[ch]++;
                if (tick_v[ch]) begin gap[ch] = since[ch]; since[ch] = 0; end
            end
        end
    end

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(logic a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read_chk(string req, logic a, logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check_eq(req, int'(bus_rdata), int'(exp));
    endtask

    // Wait until the channel's card clock moves to the level 'want'.
    task automatic wait_edge(int ch, logic want);
        logic p;
        p = cclk_v[ch];
        forever begin
            @(negedge clk); #1;
            if (cclk_v[ch] == want && p != want) break;
            p = cclk_v[ch];
        end
    endtask

    // Wait for the code to apply, then measure one full period.
    task automatic measure(int ch, int code);
        int e;
        string tag;
        e = (code == 0) ? 1 : code;
        tag = (code == 0) ? "R5" : "R4";
        wait_edge(ch, 1'b0);
        wait_edge(ch, 1'b1);
        check_eq(tag, last_lo[ch], e + 1);
        wait_edge(ch, 1'b0);
        check_eq(tag, last_hi[ch], e + 1);
        check_eq((code == 0) ? "R5" : "R3", gap[ch], e + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs and registers while in reset and just after it.
        #1;
        check_eq("R1", int'({int_cclk, ext_cclk, int_tick, ext_tick}), 0);
        rst_n = 1'b1;
        bus_read_chk("R1", 1'b0, 8'h0C);
        bus_read_chk("R1", 1'b1, 8'h0C);
        wait_edge(0, 1'b1);
        wait_edge(0, 1'b0);
        check_eq("R1", last_hi[0], 13);
        check_eq("R1", gap[0], 13);

        // R2: upper bits dropped on write, read back as zero.
        bus_write(1'b0, 8'hFF);
        bus_read_chk("R2", 1'b0, 8'h3F);
        // R7: the other channel is untouched.
        bus_read_chk("R7", 1'b1, 8'h0C);
        bus_write(1'b1, 8'hC5);
        bus_read_chk("R2", 1'b1, 8'h05);
        bus_read_chk("R7", 1'b0, 8'h3F);

        // R3 R4 R5 R7: sweep every code, different codes on each channel.
        for (int c = 0; c < 64; c++) begin
            int ce;
            ce = (c * 5 + 7) % 64;
            bus_write(1'b0, 8'(c));
            bus_write(1'b1, 8'(ce));
            measure(0, c);
            measure(1, ce);
        end
        // R7: a write to the internal channel keeps the external period.
        bus_write(1'b0, 8'd3);
        measure(1, (63 * 5 + 7) % 64);

        // R6: write during a high phase.
        bus_write(1'b0, 8'd12);
        measure(0, 12);
        wait_edge(0, 1'b1);
        repeat (3) @(negedge clk);
        bus_write(1'b0, 8'd2);
        bus_read_chk("R2", 1'b0, 8'h02);
        wait_edge(0, 1'b0);
        check_eq("R6", last_hi[0], 13);
        wait_edge(0, 1'b1);
        check_eq("R6", last_lo[0], 3);

        // R6: write during a low phase; the next high phase stays old.
        bus_write(1'b0, 8'd12);
        measure(0, 12);
        repeat (3) @(negedge clk);
        bus_write(1'b0, 8'd2);
        wait_edge(0, 1'b1);
        check_eq("R6", last_lo[0], 13);
        wait_edge(0, 1'b0);
        check_eq("R6", last_hi[0], 13);
        wait_edge(0, 1'b1);
        check_eq("R6", last_lo[0], 3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule